// File: doc/BRIEF.md
# Serial Poll Service Request Controller

This block keeps the service-request side of a device on an IEEE 488 bus. The local processor writes an 8-bit mode byte. Bit 6 of that byte is the request flag and the other seven bits hold free status. A 0-to-1 change of the flag puts the block into its request state, and the SRQ output follows that state. When the controller runs a serial poll, the block presents the status byte. When the controller accepts that byte, the request state drops and SRQ is released.

The request flag is left alone. The processor clears it once service has been granted. Because only a rising write of the flag starts a request, leaving the flag at 1 after a poll does not raise SRQ again. The processor can latch a status byte whose bit 6 shows the live request state. The same byte, in the same form, is returned during a poll.

Top module: `spoll_srq`

## Requirements
- R1: After reset the mode byte and the request state are zero, `srq_o` is low, `poll_byte_o` is 0 and `rd_data_o` is 0.
- R2: A cycle with `wr_en_i` high loads `wr_data_i` into the mode byte at that clock edge. Bits 7 and 5..0 then appear unchanged in the status byte.
- R3: A write with `wr_data_i[6]`=1 while the stored flag is 0 sets the request state at that edge. `srq_o` is high from then on.
- R4: A write with bit 6 set while the stored flag is already 1 does not set the request state.
- R5: While `spe_i` and `tad_i` are both high, `poll_byte_o` shows the mode byte with bit 6 replaced by the request state. Otherwise it is 0.
- R6: `byte_rd_i` high while `spe_i` and `tad_i` are high clears the request state at that edge, and `srq_o` goes low. The stored flag is unchanged.
- R7: `byte_rd_i` has no effect unless both `spe_i` and `tad_i` are high.
- R8: If a setting write and a clearing poll read fall in the same cycle, the request state ends up set.
- R9: Writing bit 6 as 0 does not clear the request state.
- R10: `rd_data_o` loads the status byte (mode byte with bit 6 = request state) at the edge of a cycle with `rd_en_i` high, and holds its value in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Processor write strobe for the mode byte |
| wr_data_i | input | 8 | Mode byte; bit 6 is the request flag |
| rd_en_i | input | 1 | Processor read strobe for the status byte |
| spe_i | input | 1 | Serial poll enabled by the controller |
| tad_i | input | 1 | Device addressed to talk |
| byte_rd_i | input | 1 | Controller accepted the presented byte |
| srq_o | output | 1 | Service request line (high = request) |
| poll_byte_o | output | 8 | Status byte presented during a serial poll |
| rd_data_o | output | 8 | Latched status byte for the processor |

## Verification
The mode byte, the request state and `rd_data_o` are registers. Each changes at the rising edge that ends the cycle in which its strobe is high, so the result is due one edge after the stimulus. `poll_byte_o` is combinational from the registers and the poll inputs, so it is valid in the same cycle. The bench drives and samples on the falling edge. Each registered result is checked half a cycle after the edge that updates it, and each combinational result is checked in the cycle where its inputs are applied.

// File: rtl/spoll_pkg.sv
package spoll_pkg;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned RSV_POS = 6;
endpackage

// File: rtl/spoll_mode_reg.sv
module spoll_mode_reg #(
  parameter int unsigned DATA_W  = spoll_pkg::BYTE_W,
  parameter int unsigned RSV_POS = spoll_pkg::RSV_POS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] mode_o,
  output logic              req_set_o
);
  logic [DATA_W-1:0] mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      mode_q <= '0;
    else if (wr_en_i) mode_q <= wr_data_i;
  end

  // only a rising write of the flag starts a request
  assign req_set_o = wr_en_i & wr_data_i[RSV_POS] & ~mode_q[RSV_POS];
  assign mode_o    = mode_q;
endmodule

// File: rtl/spoll_req_state.sv
module spoll_req_state (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic state_o
);
  logic state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    state_q <= 1'b0;
    else if (set_i) state_q <= 1'b1;  // new request wins over a poll read
    else if (clr_i) state_q <= 1'b0;
  end

  assign state_o = state_q;
endmodule

// File: rtl/spoll_status.sv
module spoll_status #(
  parameter int unsigned DATA_W  = spoll_pkg::BYTE_W,
  parameter int unsigned RSV_POS = spoll_pkg::RSV_POS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] mode_i,
  input  logic              state_i,
  input  logic              poll_act_i,
  input  logic              rd_en_i,
  output logic [DATA_W-1:0] poll_byte_o,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [DATA_W-1:0] merged;
  logic [DATA_W-1:0] rd_q;

  for (genvar i = 0; i < DATA_W; i++) begin : g_merge
    if (i == RSV_POS) begin : g_state
      assign merged[i] = state_i;
    end else begin : g_user
      assign merged[i] = mode_i[i];
    end
  end

  assign poll_byte_o = poll_act_i ? merged : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rd_q <= '0;
    else if (rd_en_i) rd_q <= merged;
  end

  assign rd_data_o = rd_q;
endmodule

// File: rtl/spoll_srq.sv
module spoll_srq #(
  parameter int unsigned DATA_W  = spoll_pkg::BYTE_W,
  parameter int unsigned RSV_POS = spoll_pkg::RSV_POS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  input  logic              spe_i,
  input  logic              tad_i,
  input  logic              byte_rd_i,
  output logic              srq_o,
  output logic [DATA_W-1:0] poll_byte_o,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [DATA_W-1:0] mode_w;
  logic              req_set;
  logic              req_state;
  logic              poll_act;
  logic              poll_rd;

  assign poll_act = spe_i & tad_i;
  assign poll_rd  = poll_act & byte_rd_i;

  spoll_mode_reg #(.DATA_W(DATA_W), .RSV_POS(RSV_POS)) u_mode (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .mode_o    (mode_w),
    .req_set_o (req_set)
  );

  spoll_req_state u_req (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (req_set),
    .clr_i   (poll_rd),
    .state_o (req_state)
  );

  spoll_status #(.DATA_W(DATA_W), .RSV_POS(RSV_POS)) u_stat (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mode_i      (mode_w),
    .state_i     (req_state),
    .poll_act_i  (poll_act),
    .rd_en_i     (rd_en_i),
    .poll_byte_o (poll_byte_o),
    .rd_data_o   (rd_data_o)
  );

  assign srq_o = req_state;
endmodule

// File: rtl/spoll_srq_chk.sv
module spoll_srq_chk #(
  parameter int unsigned DATA_W  = spoll_pkg::BYTE_W,
  parameter int unsigned RSV_POS = spoll_pkg::RSV_POS
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic              rd_en_i,
  input logic              spe_i,
  input logic              tad_i,
  input logic              byte_rd_i,
  input logic              flag_i,
  input logic              srq_o,
  input logic [DATA_W-1:0] poll_byte_o,
  input logic [DATA_W-1:0] rd_data_o
);
  logic set_c, clr_c;
  assign set_c = wr_en_i && wr_data_i[RSV_POS] && !flag_i;
  assign clr_c = spe_i && tad_i && byte_rd_i;

  assert_srq_set_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_c |=> srq_o);
  assert_srq_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_c && !set_c) |=> !srq_o);
  assert_no_rearm_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!srq_o && !set_c) |=> !srq_o);
  assert_hold_srq_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (srq_o && !clr_c) |=> srq_o);
  assert_poll_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(spe_i && tad_i) |-> (poll_byte_o == '0));
  assert_poll_state_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (spe_i && tad_i) |-> (poll_byte_o[RSV_POS] == srq_o));
  assert_rd_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rd_data_o));
endmodule

bind spoll_srq spoll_srq_chk #(.DATA_W(DATA_W), .RSV_POS(RSV_POS)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_en_i     (wr_en_i),
  .wr_data_i   (wr_data_i),
  .rd_en_i     (rd_en_i),
  .spe_i       (spe_i),
  .tad_i       (tad_i),
  .byte_rd_i   (byte_rd_i),
  .flag_i      (mode_w[RSV_POS]),
  .srq_o       (srq_o),
  .poll_byte_o (poll_byte_o),
  .rd_data_o   (rd_data_o)
);

// File: tb/spoll_srq_bench.sv
`timescale 1ns/1ps
module spoll_srq_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [7:0] wr_data_i = '0;
  logic       rd_en_i = 1'b0;
  logic       spe_i = 1'b0;
  logic       tad_i = 1'b0;
  logic       byte_rd_i = 1'b0;
  logic       srq_o;
  logic [7:0] poll_byte_o;
  logic [7:0] rd_data_o;

  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  spoll_srq u_spoll_srq (.*);

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk_i); wr_en_i = 1'b1; wr_data_i = d;
    @(negedge clk_i); wr_en_i = 1'b0;
  endtask

  task automatic rd_stat();
    @(negedge clk_i); rd_en_i = 1'b1;
    @(negedge clk_i); rd_en_i = 1'b0;
  endtask

  task automatic poll_read();
    @(negedge clk_i); spe_i = 1'b1; tad_i = 1'b1; byte_rd_i = 1'b1;
    @(negedge clk_i); byte_rd_i = 1'b0; spe_i = 1'b0; tad_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 srq", {7'd0, srq_o}, 8'h00);
    chk("R1 poll", poll_byte_o, 8'h00);
    chk("R1 rd", rd_data_o, 8'h00);
    rd_stat();
    chk("R1 status", rd_data_o, 8'h00);
  endtask

  task automatic t_write_status();
    wr(8'hA5);
    chk("R2 srq", {7'd0, srq_o}, 8'h00);
    rd_stat();
    chk("R2 status", rd_data_o, 8'hA5);
  endtask

  task automatic t_set();
    wr(8'hE5);
    chk("R3 srq", {7'd0, srq_o}, 8'h01);
    rd_stat();
    chk("R3 status", rd_data_o, 8'hE5);
  endtask

  task automatic t_poll_view();
    @(negedge clk_i); spe_i = 1'b1; tad_i = 1'b0;
    #1 chk("R5 no talk", poll_byte_o, 8'h00);
    tad_i = 1'b1;
    #1 chk("R5 poll", poll_byte_o, 8'hE5);
    @(negedge clk_i); spe_i = 1'b0; tad_i = 1'b0;
  endtask

  task automatic t_ignore_rd();
    @(negedge clk_i); spe_i = 1'b1; tad_i = 1'b0; byte_rd_i = 1'b1;
    @(negedge clk_i); spe_i = 1'b0; tad_i = 1'b1;
    @(negedge clk_i); byte_rd_i = 1'b0; tad_i = 1'b0;
    chk("R7 srq kept", {7'd0, srq_o}, 8'h01);
  endtask

  task automatic t_clear();
    poll_read();
    chk("R6 srq", {7'd0, srq_o}, 8'h00);
    @(negedge clk_i); spe_i = 1'b1; tad_i = 1'b1;
    #1 chk("R6 poll bit", poll_byte_o, 8'hA5);
    @(negedge clk_i); spe_i = 1'b0; tad_i = 1'b0;
  endtask

  task automatic t_no_rearm();
    wr(8'hE5);
    chk("R4 srq", {7'd0, srq_o}, 8'h00);
    wr(8'h25);
    wr(8'h65);
    chk("R4 rearm", {7'd0, srq_o}, 8'h01);
  endtask

  task automatic t_flag_clear();
    wr(8'h25);
    chk("R9 srq", {7'd0, srq_o}, 8'h01);
    rd_stat();
    chk("R9 status", rd_data_o, 8'h65);
  endtask

  task automatic t_collide();
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_data_i = 8'h45;
    spe_i = 1'b1; tad_i = 1'b1; byte_rd_i = 1'b1;
    @(negedge clk_i);
    wr_en_i = 1'b0; spe_i = 1'b0; tad_i = 1'b0; byte_rd_i = 1'b0;
    chk("R8 set wins", {7'd0, srq_o}, 8'h01);
    poll_read();
    chk("R8 then clear", {7'd0, srq_o}, 8'h00);
  endtask

  task automatic t_rd_hold();
    rd_stat();
    chk("R10 load", rd_data_o, 8'h05);
    wr(8'h11);
    @(negedge clk_i);
    chk("R10 hold", rd_data_o, 8'h05);
    rd_stat();
    chk("R10 reload", rd_data_o, 8'h11);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_write_status();
    t_set();
    t_poll_view();
    t_ignore_rd();
    t_clear();
    t_no_rearm();
    t_flag_clear();
    t_collide();
    t_rd_hold();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule